// File: doc/BRIEF.md
# Variable-Width Bitfield Unpacker

This block expands a run of equal-width bitfields, packed back to back at the low end of a 64-bit source word, into a 64-bit result with one field per lane. A 5-bit selector sets the field width to selector+1 bits. The same selector also sets the lane format. Values 0 to 7 give eight 8-bit lanes, 8 to 15 give four 16-bit lanes, and 16 to 31 give two 32-bit lanes. Each field is right-justified in its lane, and the lane bits above it are zero.

The unpack logic is purely combinational. A parameter adds an output register stage with a valid strobe. In that mode the result appears one cycle after the input strobe and holds until the next one. Source and result are raw bit vectors with no numeric meaning.

Top module: `bitfield_unpack`

## Requirements
- R1: With sel_i from 0 to 7, res_o holds eight 8-bit lanes, each filled from a field of sel_i+1 bits.
- R2: With sel_i from 8 to 15, res_o holds four 16-bit lanes, each filled from a field of sel_i+1 bits.
- R3: With sel_i from 16 to 31, res_o holds two 32-bit lanes, each filled from a field of sel_i+1 bits.
- R4: Field k starts at source bit k*(sel_i+1), counting from bit 0, and lands in lane k; lane 0 is res_o's least significant lane, and the field's bit 0 lands in the lane's bit 0.
- R5: Lane bits at or above the field width are zero.
- R6: Source bits above the last field used have no effect on res_o.
- R7: With the output register fitted, valid_o is high in the cycle after each cycle in which valid_i is sampled high, and low otherwise; res_o then carries the unpack of the sampled src_i and sel_i.
- R8: While rst_ni is low, valid_o and res_o are zero.
- R9: With the output register fitted, res_o keeps its value across cycles in which valid_i is low, whatever src_i and sel_i do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output stage |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input strobe; captures src_i and sel_i |
| sel_i | input | 5 | Field width minus one; its range picks the lane format |
| src_i | input | 64 | Packed source word |
| valid_o | output | 1 | Result strobe |
| res_o | output | 64 | Unpacked lanes |

## Verification
The hardest cases are the ones where a field spans a byte boundary of the source and where the fields end well below bit 63. These are widths such as 9, 12 or 17 bits, where a lane index times the width lands mid-byte, and narrow widths in which most of the source must be ignored. To reach them, the bench walks every selector value with several random source words. It also applies hand-built words that carry ones above the last field and distinct nibble patterns, so that a misplaced shift or mask shows up as a wrong lane value. A reference model that copies bits one at a time supplies the expected results.

// File: rtl/unpk_pkg.sv
package unpk_pkg;

  typedef enum logic [1:0] {
    FMT_B8  = 2'd0,
    FMT_H16 = 2'd1,
    FMT_W32 = 2'd2
  } lane_fmt_e;

  localparam int unsigned NUM_FMTS  = 3;
  localparam int unsigned BASE_LANE = 8;

  function automatic int unsigned fmt_lane_w(input int unsigned f);
    return BASE_LANE << f;
  endfunction

endpackage

// File: rtl/unpk_mode_dec.sv
module unpk_mode_dec
  import unpk_pkg::*;
#(
  parameter int unsigned SEL_W = 5,
  localparam int unsigned FW_W = SEL_W + 1
) (
  input  logic [SEL_W-1:0] sel_i,
  output lane_fmt_e        fmt_o,
  output logic [FW_W-1:0]  fw_o
);

  // field width is selector plus one
  assign fw_o = FW_W'(sel_i) + FW_W'(1);

  always_comb begin
    if (sel_i[SEL_W-1])      fmt_o = FMT_W32;
    else if (sel_i[SEL_W-2]) fmt_o = FMT_H16;
    else                     fmt_o = FMT_B8;
  end

  always_comb begin
    if (fmt_o == FMT_B8)  a_r1_b8_width:  assert (fw_o >= FW_W'(1)  && fw_o <= FW_W'(8));
    if (fmt_o == FMT_H16) a_r2_h16_width: assert (fw_o >= FW_W'(9)  && fw_o <= FW_W'(16));
    if (fmt_o == FMT_W32) a_r3_w32_width: assert (fw_o >= FW_W'(17) && fw_o <= FW_W'(32));
  end

endmodule

// File: rtl/unpk_lane_fmt.sv
module unpk_lane_fmt #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned FW_W   = 6,
  localparam int unsigned NUM_LANES = DATA_W / LANE_W,
  localparam int unsigned SH_W      = $clog2(DATA_W) + FW_W
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [FW_W-1:0]   fw_i,
  output logic [DATA_W-1:0] res_o
);

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    logic [SH_W-1:0]   sh_amt;
    logic [DATA_W-1:0] shifted;
    logic [LANE_W-1:0] mask;

    assign sh_amt  = SH_W'(k) * SH_W'(fw_i);
    assign shifted = src_i >> sh_amt;

    always_comb begin
      for (int b = 0; b < LANE_W; b++) begin
        mask[b] = (b < int'(fw_i));
      end
    end

    assign res_o[k*LANE_W +: LANE_W] = shifted[LANE_W-1:0] & mask;
  end

endmodule

// File: rtl/bitfield_unpack.sv
module bitfield_unpack
  import unpk_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned SEL_W   = 5,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned FW_W   = SEL_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] src_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] res_o
);

  lane_fmt_e         fmt;
  logic [FW_W-1:0]   fw;
  logic [DATA_W-1:0] res_fmt [NUM_FMTS];
  logic [DATA_W-1:0] res_comb;

  unpk_mode_dec #(.SEL_W(SEL_W)) u_dec (
    .sel_i (sel_i),
    .fmt_o (fmt),
    .fw_o  (fw)
  );

  for (genvar f = 0; f < NUM_FMTS; f++) begin : g_fmt
    unpk_lane_fmt #(
      .DATA_W (DATA_W),
      .LANE_W (fmt_lane_w(f)),
      .FW_W   (FW_W)
    ) u_fmt (
      .src_i (src_i),
      .fw_i  (fw),
      .res_o (res_fmt[f])
    );
  end

  always_comb begin
    unique case (fmt)
      FMT_H16: res_comb = res_fmt[1];
      FMT_W32: res_comb = res_fmt[2];
      default: res_comb = res_fmt[0];
    endcase
  end

  // zero fill above field, and lane 0 carries the lowest field
  always_comb begin
    if (fmt == FMT_B8) begin
      for (int k = 0; k < int'(DATA_W) / 8; k++)
        a_r5_zero_fill_b8: assert ((res_comb[k*8 +: 8] >> fw) == '0);
    end
    if (fmt == FMT_H16) begin
      for (int k = 0; k < int'(DATA_W) / 16; k++)
        a_r5_zero_fill_h16: assert ((res_comb[k*16 +: 16] >> fw) == '0);
    end
    if (fmt == FMT_W32) begin
      for (int k = 0; k < int'(DATA_W) / 32; k++)
        a_r5_zero_fill_w32: assert ((res_comb[k*32 +: 32] >> fw) == '0);
    end
    for (int b = 0; b < 32; b++) begin
      if (b < int'(fw)) a_r4_lane0_bits: assert (res_comb[b] == src_i[b]);
    end
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        res_o   <= '0;
      end else begin
        valid_o <= valid_i;
        if (valid_i) res_o <= res_comb;
      end
    end

    a_r7_valid_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);
    a_r7_valid_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o);
    a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(res_o));

    always @(posedge clk_i) begin
      if (!rst_ni) a_r8_reset_clear: assert (!valid_o && res_o == '0);
    end
  end else begin : g_comb
    assign valid_o = valid_i;
    assign res_o   = res_comb;
  end

endmodule

// File: tb/bitfield_unpack_tb_top.sv
`timescale 1ns/1ps
module bitfield_unpack_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [4:0]  sel_i = '0;
  logic [63:0] src_i = '0;
  logic        valid_o;
  logic [63:0] res_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;

  bitfield_unpack dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .sel_i   (sel_i),
    .src_i   (src_i),
    .valid_o (valid_o),
    .res_o   (res_o)
  );

  typedef struct packed {
    logic [4:0]  sel;
    logic [63:0] src;
    logic [63:0] exp;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{5'd7,  64'h0123456789ABCDEF, 64'h0123456789ABCDEF}, // R1 identity
    '{5'd15, 64'h0123456789ABCDEF, 64'h0123456789ABCDEF}, // R2 identity
    '{5'd31, 64'h0123456789ABCDEF, 64'h0123456789ABCDEF}, // R3 identity
    '{5'd0,  64'hFFFFFFFFFFFFFFA5, 64'h0100010000010001}, // R6 1-bit fields
    '{5'd3,  64'hFFFFFFFF87654321, 64'h0807060504030201}, // R4 nibble order
    '{5'd8,  64'hFFFFFFFFFFFFFFFF, 64'h01FF01FF01FF01FF}, // R5 9-bit fields
    '{5'd16, 64'hFFFFFFFFFFFFFFFF, 64'h0001FFFF0001FFFF}, // R5 17-bit fields
    '{5'd11, 64'hFFFFCBA987654321, 64'h0CBA098706540321}, // R4 12-bit fields
    '{5'd31, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF}  // R3 full lanes
  };

  function automatic logic [63:0] ref_unpack(input logic [4:0] s, input logic [63:0] x);
    logic [63:0] r;
    int w, lw;
    r  = '0;
    w  = int'(s) + 1;
    lw = (s < 5'd8) ? 8 : (s < 5'd16) ? 16 : 32;
    for (int k = 0; k < 64 / lw; k++)
      for (int b = 0; b < w; b++)
        r[k*lw + b] = x[k*w + b];
    return r;
  endfunction

  function automatic string fmt_tag(input logic [4:0] s);
    if (s < 5'd8)  return "R1";
    if (s < 5'd16) return "R2";
    return "R3";
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one strobe; result and valid sampled one cycle later
  task automatic apply(input logic [4:0] s, input logic [63:0] x, output logic [63:0] got);
    @(negedge clk_i);
    valid_i = 1'b1;
    sel_i   = s;
    src_i   = x;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R7 valid", 64'(valid_o), 64'd1);
    got = res_o;
  endtask

  initial begin
    logic [63:0] got, held;
    repeat (3) @(negedge clk_i);
    chk("R8 valid in reset", 64'(valid_o), 64'd0);
    chk("R8 res in reset", res_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R8 valid after reset", 64'(valid_o), 64'd0);

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].sel, VECS[i].src, got);
      chk($sformatf("%s/R4/R5/R6 table %0d", fmt_tag(VECS[i].sel), i), got, VECS[i].exp);
    end

    for (int s = 0; s < 32; s++) begin
      for (int j = 0; j < 6; j++) begin
        logic [63:0] x;
        x = {$urandom, $urandom};
        apply(5'(s), x, got);
        chk($sformatf("%s sel=%0d", fmt_tag(5'(s)), s), got, ref_unpack(5'(s), x));
      end
    end

    // R6: upper bits past last field
    apply(5'd4, 64'h0000_0000_0000_0000, held);
    apply(5'd4, 64'hFFFFFF00_00000000, got);
    chk("R6 ignored bits sel=4", got, held);

    // R7: valid drops one cycle after strobe ends
    apply(5'd9, 64'h1234_5678_9ABC_DEF0, held);
    chk("R7 data", held, ref_unpack(5'd9, 64'h1234_5678_9ABC_DEF0));
    @(negedge clk_i);
    chk("R7 valid low", 64'(valid_o), 64'd0);

    // R9: inputs toggle with valid low
    for (int c = 0; c < 4; c++) begin
      sel_i = 5'(c * 7);
      src_i = {$urandom, $urandom};
      @(negedge clk_i);
      chk("R9 hold", res_o, held);
    end

    // R8: reset mid-run
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R8 res after reassert", res_o, 64'd0);
    chk("R8 valid after reassert", 64'(valid_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule